// File: doc/BRIEF.md
# Hybrid Priority Round-Robin Arbiter

This block decides which of a set of channel request lines gets the next transfer slot between a channel buffer and the DMA engine. A 2-bit mode input picks how many of the lowest-numbered channels form a fixed-priority group: none, the lowest 2, the lowest 16 or the lowest 64. Every other channel shares service in rotating round-robin order. Any pending request in the fixed group beats every round-robin request. Inside the fixed group, the lower channel number wins.

A grant is registered and stays on the outputs until the consumer pulses the accept strobe. In the cycle of an accept, the arbiter picks the next winner, so requests held high get one grant per cycle with no idle cycle in between. The round-robin pointer moves only when a round-robin grant is accepted. It moves to the channel just after the granted one. The receive and transmit directions each use their own instance, and each instance has its own mode input.

Top module: `hybrid_prio_rr_arb`

## Requirements
- R1: While reset is asserted and after its release with no request pending, `grant_valid_o` is 0 and `grant_o` is all zeros. The round-robin pointer starts at channel 0.
- R2: With `mode_i` = 2'b00, every channel is round robin. The winner is the lowest requesting channel at or above the pointer. If there is none, the winner is the lowest requesting channel overall.
- R3: With `mode_i` = 2'b01, channels 0 and 1 are fixed priority and channels 2 and up are round robin.
- R4: With `mode_i` = 2'b10, channels 0 to 15 are fixed priority and channels 16 and up are round robin.
- R5: With `mode_i` = 2'b11, channels 0 to 63 are fixed priority and channels 64 and up are round robin.
- R6: When several fixed-group channels are requesting, the lowest-numbered one is granted.
- R7: Any fixed-group request wins over every round-robin request.
- R8: Accepting a round-robin grant for channel c sets the pointer to c+1, wrapping from the top channel to 0. Accepting a fixed-group grant leaves the pointer unchanged. A grant is classed fixed or round robin by the mode in force when it was issued.
- R9: When no grant is held, or the held grant is accepted, and no request is pending, `grant_valid_o` goes low on the next edge. An accept while no grant is held has no effect.
- R10: A grant that has been issued holds its channel number while `accept_i` is low, even if the requests or the mode change.
- R11: A mode change takes effect at the next arbitration, meaning the next edge with no grant held or with an accept.
- R12: `grant_o` has exactly the bit `grant_id_o` set while `grant_valid_o` is 1, and is all zeros otherwise.
- R13: The round-robin search wraps past the top channel to the lowest requesting round-robin channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 256 | Request line per channel, bit c for channel c |
| mode_i | input | 2 | Size of the fixed-priority group (00 none, 01 two, 10 sixteen, 11 sixty-four) |
| accept_i | input | 1 | Consumer takes the held grant on this edge |
| grant_o | output | 256 | One-hot grant vector |
| grant_id_o | output | 8 | Encoded granted channel number |
| grant_valid_o | output | 1 | A grant is held |

## Verification
Two things can happen on the same edge: the pointer advances for an accepted round-robin grant, and the next winner is chosen. The next winner must be chosen from the advanced pointer, not the old one. The bench provokes this by holding `accept_i` high against a fixed set of requests, so every edge does both. A scoreboard compares the consumed order against sequences worked out by hand, including sequences that wrap past the top channel. A second collision, where a mode or request change arrives while a grant is held, is judged by checking that the held number stays put and that the following grant follows the new mode.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

  typedef enum logic [1:0] {
    ARB_ALL_RR    = 2'b00,
    ARB_FIX_SMALL = 2'b01,
    ARB_FIX_MID   = 2'b10,
    ARB_FIX_LARGE = 2'b11
  } arb_mode_e;

  // Number of lowest channels served by fixed priority, clamped to the channel count.
  function automatic int unsigned fix_count(arb_mode_e m, int unsigned sz_small,
                                            int unsigned sz_mid, int unsigned sz_large,
                                            int unsigned n_ch);
    int unsigned c;
    case (m)
      ARB_FIX_SMALL: c = sz_small;
      ARB_FIX_MID:   c = sz_mid;
      ARB_FIX_LARGE: c = sz_large;
      default:       c = 0;
    endcase
    return (c > n_ch) ? n_ch : c;
  endfunction

endpackage

// File: rtl/hpa_first_set.sv
module hpa_first_set #(
  parameter int unsigned N = 256,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
    found_o = |vec_i;
  end

endmodule

// File: rtl/hpa_rr_pick.sv
module hpa_rr_pick #(
  parameter int unsigned N = 256,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] cand_i,
  input  logic [W-1:0] base_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);

  logic [N-1:0] upper;
  logic         up_found;
  logic [W-1:0] up_idx;
  logic         all_found;
  logic [W-1:0] all_idx;

  always_comb begin
    for (int unsigned i = 0; i < N; i++) begin
      upper[i] = cand_i[i] && (W'(i) >= base_i);
    end
  end

  hpa_first_set #(.N(N), .W(W)) upper_fs_i (
    .vec_i   (upper),
    .found_o (up_found),
    .idx_o   (up_idx)
  );

  hpa_first_set #(.N(N), .W(W)) wrap_fs_i (
    .vec_i   (cand_i),
    .found_o (all_found),
    .idx_o   (all_idx)
  );

  assign found_o = all_found;
  assign idx_o   = up_found ? up_idx : all_idx;

endmodule

// File: rtl/hybrid_prio_rr_arb.sv
module hybrid_prio_rr_arb #(
  parameter int unsigned N_CH      = 256,
  parameter int unsigned FIX_SMALL = 2,
  parameter int unsigned FIX_MID   = 16,
  parameter int unsigned FIX_LARGE = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CH-1:0]         req_i,
  input  logic [1:0]              mode_i,
  input  logic                    accept_i,
  output logic [N_CH-1:0]         grant_o,
  output logic [$clog2(N_CH)-1:0] grant_id_o,
  output logic                    grant_valid_o
);
  import hpa_pkg::*;

  localparam int unsigned CH_W = $clog2(N_CH);
  localparam logic [CH_W-1:0] TOP_CH = CH_W'(N_CH - 1);

  // state
  logic            grant_valid_q, grant_valid_d;
  logic [CH_W-1:0] grant_id_q, grant_id_d;
  logic            grant_rr_q, grant_rr_d;
  logic [CH_W-1:0] rr_ptr_q, rr_ptr_d;

  // arbitration
  int unsigned     fix_lim;
  logic [N_CH-1:0] fix_mask;
  logic [N_CH-1:0] fix_req, rr_req;
  logic            load_en, ptr_adv;
  logic            fx_found, rr_found;
  logic [CH_W-1:0] fx_idx, rr_idx;

  always_comb begin
    fix_lim = fix_count(arb_mode_e'(mode_i), FIX_SMALL, FIX_MID, FIX_LARGE, N_CH);
    for (int unsigned i = 0; i < N_CH; i++) begin
      fix_mask[i] = (i < fix_lim);
    end
    fix_req = req_i & fix_mask;
    rr_req  = req_i & ~fix_mask;
  end

  assign load_en = !grant_valid_q || accept_i;
  assign ptr_adv = grant_valid_q && accept_i && grant_rr_q;

  always_comb begin
    rr_ptr_d = rr_ptr_q;
    if (ptr_adv) rr_ptr_d = (grant_id_q == TOP_CH) ? '0 : grant_id_q + 1'b1;
  end

  hpa_first_set #(.N(N_CH), .W(CH_W)) fixed_fs_i (
    .vec_i   (fix_req),
    .found_o (fx_found),
    .idx_o   (fx_idx)
  );

  hpa_rr_pick #(.N(N_CH), .W(CH_W)) rr_pick_i (
    .cand_i  (rr_req),
    .base_i  (rr_ptr_d),
    .found_o (rr_found),
    .idx_o   (rr_idx)
  );

  always_comb begin
    grant_valid_d = fx_found || rr_found;
    grant_id_d    = fx_found ? fx_idx : (rr_found ? rr_idx : grant_id_q);
    grant_rr_d    = !fx_found && rr_found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid_q <= 1'b0;
      grant_id_q    <= '0;
      grant_rr_q    <= 1'b0;
      rr_ptr_q      <= '0;
    end else begin
      if (load_en) begin
        grant_valid_q <= grant_valid_d;
        grant_id_q    <= grant_id_d;
        grant_rr_q    <= grant_rr_d;
      end
      if (ptr_adv) rr_ptr_q <= rr_ptr_d;
    end
  end

  always_comb begin
    grant_o = '0;
    if (grant_valid_q) grant_o[grant_id_q] = 1'b1;
  end

  assign grant_id_o    = grant_id_q;
  assign grant_valid_o = grant_valid_q;

  // assertions
  assert_onehot_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (grant_valid_o == (|grant_o)));

  assert_hold_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && !accept_i |=> grant_valid_o && $stable(grant_id_o));

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid_o || accept_i) && (req_i == '0) |=> !grant_valid_o);

  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid_o || accept_i) && (|req_i) |=> grant_valid_o && (|($past(req_i) & grant_o)));

  assert_fixed_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && (|fix_req) |=> grant_valid_o && !grant_rr_q);

  assert_ptr_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o && accept_i && !grant_rr_q |=> $stable(rr_ptr_q));

endmodule

// File: tb/hybrid_prio_rr_arb_tb_top.sv
`timescale 1ns/1ps
module hybrid_prio_rr_arb_tb_top;

  localparam int N = 256;
  localparam int W = $clog2(N);

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic [1:0]   mode;
  logic         acc;
  logic [N-1:0] grant_o;
  logic [W-1:0] grant_id_o;
  logic         grant_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  hybrid_prio_rr_arb dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req),
    .mode_i        (mode),
    .accept_i      (acc),
    .grant_o       (grant_o),
    .grant_id_o    (grant_id_o),
    .grant_valid_o (grant_valid_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] chs(int a, int b = -1, int c = -1);
    logic [N-1:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  task automatic push(int id, string tag);
    exp_q.push_back(id);
    tag_q.push_back(tag);
  endtask

  task automatic drive(logic [N-1:0] r, logic [1:0] m, logic a);
    @(posedge clk);
    #2;
    req = r; mode = m; acc = a;
  endtask

  // K cycles of requests with accept held, then one flush cycle: K grants consumed
  task automatic run_case(logic [N-1:0] r, logic [1:0] m, int k);
    for (int i = 0; i < k; i++) drive(r, m, 1'b1);
    drive('0, m, 1'b1);
  endtask

  // monitor: a grant seen with accept high is consumed at the next edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done && grant_valid_o && acc) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected grant", int'(grant_id_o), -1);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(grant_id_o) == e, t, int'(grant_id_o), e);
        check(grant_o == (N'(1) << grant_id_o), "R12 one-hot", int'($countones(grant_o)), 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; mode = 2'b00; acc = 1'b0;
    @(negedge clk);
    check(!grant_valid_o && grant_o == '0, "R1 in reset", int'(grant_valid_o), 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(!grant_valid_o && grant_o == '0, "R1 after reset", int'(grant_valid_o), 0);

    // R9: accept while idle has no effect, valid stays low
    repeat (3) drive('0, 2'b00, 1'b1);
    @(negedge clk);
    check(!grant_valid_o && grant_o == '0, "R9 idle", int'(grant_valid_o), 0);

    // R2 / R13: all round robin, ptr 0 -> 3,10,200, wrap to 3,10 ; ptr ends 11
    push(3, "R2 rr"); push(10, "R2 rr"); push(200, "R2 rr");
    push(3, "R13 wrap"); push(10, "R2 rr");
    run_case(chs(3, 10, 200), 2'b00, 5);

    // R3 / R7: channel 1 fixed beats 5 and 100 ; pointer stays 11
    push(1, "R3 fixed"); push(1, "R7 fixed wins"); push(1, "R7 fixed wins");
    run_case(chs(1, 5, 100), 2'b01, 3);
    // R8: pointer untouched by fixed grants, so 100 before 5 ; ptr ends 6
    push(100, "R8 ptr kept"); push(5, "R13 wrap");
    run_case(chs(5, 100), 2'b01, 2);

    // R4 / R6: 7 and 15 fixed, 16 round robin
    push(7, "R6 lowest fixed"); push(7, "R6 lowest fixed");
    run_case(chs(7, 15, 16), 2'b10, 2);
    push(15, "R4 edge fixed");
    run_case(chs(15, 16), 2'b10, 1);
    push(16, "R4 rr"); push(40, "R8 ptr moves");
    run_case(chs(16, 40), 2'b10, 2);   // ptr ends 41

    // R5: 63 fixed, 64 and 70 round robin
    push(63, "R5 fixed"); push(63, "R5 fixed");
    run_case(chs(63, 64, 70), 2'b11, 2);
    push(64, "R5 rr"); push(70, "R5 rr");
    run_case(chs(64, 70), 2'b11, 2);   // ptr ends 71
    // R11: mode 10 makes 63 round robin, so rotation 63 then 64 ; ptr ends 65
    push(63, "R11 new mode"); push(64, "R11 new mode");
    run_case(chs(63, 64), 2'b10, 2);

    // R10 / R11: grant held while requests and mode change
    repeat (3) drive(chs(20, 30), 2'b00, 1'b0);
    @(negedge clk);
    check(grant_valid_o && grant_id_o == 20, "R10 issued", int'(grant_id_o), 20);
    repeat (2) drive(chs(30), 2'b11, 1'b0);
    @(negedge clk);
    check(grant_valid_o && grant_id_o == 20, "R10 held", int'(grant_id_o), 20);
    check(grant_o[20] && $countones(grant_o) == 1, "R12 held one-hot", int'($countones(grant_o)), 1);
    push(20, "R10 released"); push(30, "R11 fixed after change");
    drive(chs(30), 2'b11, 1'b1);
    drive('0, 2'b11, 1'b1);
    drive('0, 2'b11, 1'b0);
    @(negedge clk);
    check(!grant_valid_o && grant_o == '0, "R9 drained", int'(grant_valid_o), 0);
    check(exp_q.size() == 0, "R2 all grants seen", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule